// File: doc/BRIEF.md
# Multi-Level Strided Copy Address Generator

This block expands one grouped copy descriptor into a stream of per-row burst commands for a DMA engine that moves data from a local buffer out to global memory. A descriptor has a source base, a destination base, a per-row byte length, an innermost row group, and up to two optional outer repeat groups. Each group carries its own repeat count, source stride and destination stride. Every stride is the start-to-start byte distance between consecutive repetitions at its own level.

The descriptor is captured on a single-cycle start pulse. The block then presents one command per row on a valid/ready interface. Each command holds a source address, a destination address and a byte length. Rows are ordered odometer-style: the row index advances fastest, then the first outer group, then the second. Each outer group wraps everything inside it. Source rows occupy 32-byte-aligned slots, but each command carries only the burst length, so the slot padding never reaches the destination. Bad descriptors are rejected at once with an error flag, and no command is issued for them.

Top module: `strided_dma_agen`

## Requirements
- R1: After reset, cmd_valid_o, busy_o, done_o and err_o are all low.
- R2: A start pulse with a legal descriptor raises cmd_valid_o and busy_o in the next cycle. The first command is then (src_base_i, dst_base_i, burst_len_i).
- R3: The command for indices (i0,i1,i2) has source address src_base + i0*row_src_stride + i1*s1 + i2*s2 modulo 2^32, and destination address dst_base + i0*row_dst_stride + i1*d1 + i2*d2 modulo 2^48. Strides are unsigned and zero-extended. i0 counts rows and runs fastest, then i1 (outer group 0, bits [20:0] of the packed outer fields), then i2 (outer group 1, bits [41:21]; destination strides at [39:0] and [79:40]). Exactly rows*n1*n2 commands are issued.
- R4: An outer group whose bit in outer_en_i is 0 (bit 0 for group 0, bit 1 for group 1) acts as count 1. Its count and strides have no effect, and a count of zero is legal for it.
- R5: While cmd_valid_o is high and cmd_ready_i is low, the command fields stay unchanged. A command is consumed only on a cycle with both high.
- R6: One cycle after the last command is accepted, done_o is high for exactly one cycle with err_o low, and cmd_valid_o and busy_o are low.
- R7: A row count of zero, a zero count in an enabled outer group, or a source base whose low 5 bits are nonzero is illegal. One cycle after start, done_o and err_o are both high for one cycle, and no command is issued.
- R8: Start pulses and descriptor input changes while busy_o is high have no effect on the running command sequence.
- R9: cmd_len_o equals the captured burst length on every command of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture descriptor and begin (ignored while busy) |
| src_base_i | input | 32 | Local-buffer source base address |
| dst_base_i | input | 48 | Global-memory destination base address |
| burst_len_i | input | 16 | Bytes per row |
| row_cnt_i | input | 16 | Innermost row count |
| row_src_stride_i | input | 21 | Source start-to-start distance between rows |
| row_dst_stride_i | input | 40 | Destination start-to-start distance between rows |
| outer_en_i | input | 2 | Enable per outer group |
| outer_cnt_i | input | 42 | Packed outer counts, group 0 in low bits |
| outer_src_stride_i | input | 42 | Packed outer source strides |
| outer_dst_stride_i | input | 80 | Packed outer destination strides |
| cmd_valid_o | output | 1 | Command available |
| cmd_ready_i | input | 1 | Command accepted by consumer |
| cmd_src_o | output | 32 | Row source address |
| cmd_dst_o | output | 48 | Row destination address |
| cmd_len_o | output | 16 | Row byte count |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Set with done_o when the descriptor was rejected |

## Verification
The bench targets carries between levels.

- **Outer-level carry.** A design that failed to reload the inner address from the outer level's running base would drift by the leftover inner stride after each wrap.
- **Disabled groups.** Groups with garbage counts and strides are used to catch logic that reads a disabled group's fields, which would repeat rows or shift addresses.
- **Wrap-around.** Maximal strides push sums past 2^32 and 2^48 to expose a wrong width or sign extension.
- **Stalls and mid-operation starts.** Random back-pressure, with start pulses and scrambled descriptor inputs during an operation, exposes fields that are read live instead of captured, and commands that move while stalled.
- **Rejected descriptors.** Zero counts and misaligned bases must end with done and error and no valid; a 32-aligned base with bit 5 set must still be accepted.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } agen_state_e;
endpackage

// File: rtl/agen_level_ctr.sv
module agen_level_ctr #(
  parameter int CNT_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q, idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      cnt_q <= cnt_i;
      idx_q <= '0;
    end else if (clr_i) begin
      idx_q <= '0;
    end else if (inc_i) begin
      idx_q <= idx_q + CNT_W'(1);
    end
  end

  assign last_o = (idx_q == cnt_q - CNT_W'(1));

  assert_idx_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (idx_q < cnt_q));
endmodule

// File: rtl/agen_addr_acc.sv
module agen_addr_acc #(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 21,
  parameter int LEVELS   = 3,
  parameter int LVL_W    = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             load_i,
  input  logic [ADDR_W-1:0]                base_i,
  input  logic [LEVELS-1:0][STRIDE_W-1:0]  stride_i,
  input  logic                             step_i,
  input  logic [LVL_W-1:0]                 step_lvl_i,
  output logic [ADDR_W-1:0]                addr_o
);
  // base_q[k]: start address of the current repetition at level k
  logic [LEVELS-1:0][ADDR_W-1:0]   base_q;
  logic [LEVELS-1:0][STRIDE_W-1:0] stride_q;
  logic [ADDR_W-1:0]               sel_base, nxt_addr;
  logic [STRIDE_W-1:0]             sel_stride;

  always_comb begin
    sel_base   = base_q[0];
    sel_stride = stride_q[0];
    for (int i = 0; i < LEVELS; i++) begin
      if (step_lvl_i == LVL_W'(i)) begin
        sel_base   = base_q[i];
        sel_stride = stride_q[i];
      end
    end
    nxt_addr = sel_base + ADDR_W'(sel_stride);
  end

  for (genvar j = 0; j < LEVELS; j++) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[j]   <= '0;
        stride_q[j] <= '0;
      end else if (load_i) begin
        base_q[j]   <= base_i;
        stride_q[j] <= stride_i[j];
      end else if (step_i && (step_lvl_i >= LVL_W'(j))) begin
        base_q[j]   <= nxt_addr;
      end
    end
  end

  assign addr_o = base_q[0];
endmodule

// File: rtl/agen_seq_ctrl.sv
module agen_seq_ctrl
  import agen_pkg::*;
#(
  parameter int LEVELS = 3,
  parameter int LVL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              desc_ok_i,
  input  logic [LEVELS-1:0] last_i,
  input  logic              ready_i,
  output logic              load_o,
  output logic              step_o,
  output logic [LVL_W-1:0]  step_lvl_o,
  output logic              valid_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  agen_state_e state_q;
  logic        done_q, err_q, fire, finish;

  assign fire   = (state_q == ST_RUN) && ready_i;
  assign finish = &last_i;
  assign load_o = (state_q == ST_IDLE) && start_i && desc_ok_i;
  assign step_o = fire && !finish;

  // lowest level not yet at its last index takes the step
  always_comb begin
    step_lvl_o = '0;
    for (int i = LEVELS - 1; i >= 0; i--) begin
      if (!last_i[i]) step_lvl_o = LVL_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          if (desc_ok_i) begin
            state_q <= ST_RUN;
          end else begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end
        end
        ST_RUN: if (fire && finish) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign valid_o = (state_q == ST_RUN);
  assign busy_o  = (state_q == ST_RUN);
  assign done_o  = done_q;
  assign err_o   = err_q;

  assert_err_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !valid_o));
  assert_last_accept_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && finish) |=> (done_o && !err_o));
endmodule

// File: rtl/strided_dma_agen.sv
module strided_dma_agen #(
  parameter int SRC_W        = 32,
  parameter int DST_W        = 48,
  parameter int LEN_W        = 16,
  parameter int ROW_CNT_W    = 16,
  parameter int LOOP_CNT_W   = 21,
  parameter int SRC_STRIDE_W = 21,
  parameter int DST_STRIDE_W = 40,
  parameter int OUTER_LEVELS = 2,
  parameter int ALIGN_BITS   = 5
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 start_i,
  input  logic [SRC_W-1:0]                     src_base_i,
  input  logic [DST_W-1:0]                     dst_base_i,
  input  logic [LEN_W-1:0]                     burst_len_i,
  input  logic [ROW_CNT_W-1:0]                 row_cnt_i,
  input  logic [SRC_STRIDE_W-1:0]              row_src_stride_i,
  input  logic [DST_STRIDE_W-1:0]              row_dst_stride_i,
  input  logic [OUTER_LEVELS-1:0]              outer_en_i,
  input  logic [OUTER_LEVELS*LOOP_CNT_W-1:0]   outer_cnt_i,
  input  logic [OUTER_LEVELS*SRC_STRIDE_W-1:0] outer_src_stride_i,
  input  logic [OUTER_LEVELS*DST_STRIDE_W-1:0] outer_dst_stride_i,
  output logic                                 cmd_valid_o,
  input  logic                                 cmd_ready_i,
  output logic [SRC_W-1:0]                     cmd_src_o,
  output logic [DST_W-1:0]                     cmd_dst_o,
  output logic [LEN_W-1:0]                     cmd_len_o,
  output logic                                 busy_o,
  output logic                                 done_o,
  output logic                                 err_o
);
  localparam int LEVELS = OUTER_LEVELS + 1;
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int CNT_W  = (LOOP_CNT_W > ROW_CNT_W) ? LOOP_CNT_W : ROW_CNT_W;

  logic [LEVELS-1:0][CNT_W-1:0]        lvl_cnt;
  logic [LEVELS-1:0][SRC_STRIDE_W-1:0] src_str;
  logic [LEVELS-1:0][DST_STRIDE_W-1:0] dst_str;
  logic [LEVELS-1:0]                   lvl_last;
  logic                                desc_ok, load, step;
  logic [LVL_W-1:0]                    step_lvl;
  logic [LEN_W-1:0]                    len_q;

  assign lvl_cnt[0] = CNT_W'(row_cnt_i);
  assign src_str[0] = row_src_stride_i;
  assign dst_str[0] = row_dst_stride_i;

  // disabled outer group collapses to a single pass
  for (genvar g = 0; g < OUTER_LEVELS; g++) begin : g_outer
    assign lvl_cnt[g+1] = outer_en_i[g] ? CNT_W'(outer_cnt_i[g*LOOP_CNT_W +: LOOP_CNT_W])
                                        : CNT_W'(1);
    assign src_str[g+1] = outer_src_stride_i[g*SRC_STRIDE_W +: SRC_STRIDE_W];
    assign dst_str[g+1] = outer_dst_stride_i[g*DST_STRIDE_W +: DST_STRIDE_W];
  end

  always_comb begin
    desc_ok = (src_base_i[ALIGN_BITS-1:0] == '0);
    for (int i = 0; i < LEVELS; i++) begin
      if (lvl_cnt[i] == '0) desc_ok = 1'b0;
    end
  end

  agen_seq_ctrl #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .desc_ok_i  (desc_ok),
    .last_i     (lvl_last),
    .ready_i    (cmd_ready_i),
    .load_o     (load),
    .step_o     (step),
    .step_lvl_o (step_lvl),
    .valid_o    (cmd_valid_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  for (genvar g = 0; g < LEVELS; g++) begin : g_ctr
    agen_level_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .cnt_i  (lvl_cnt[g]),
      .inc_i  (step && (step_lvl == LVL_W'(g))),
      .clr_i  (step && (step_lvl > LVL_W'(g))),
      .last_o (lvl_last[g])
    );
  end

  agen_addr_acc #(.ADDR_W(SRC_W), .STRIDE_W(SRC_STRIDE_W), .LEVELS(LEVELS), .LVL_W(LVL_W)) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .base_i     (src_base_i),
    .stride_i   (src_str),
    .step_i     (step),
    .step_lvl_i (step_lvl),
    .addr_o     (cmd_src_o)
  );

  agen_addr_acc #(.ADDR_W(DST_W), .STRIDE_W(DST_STRIDE_W), .LEVELS(LEVELS), .LVL_W(LVL_W)) u_dst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .base_i     (dst_base_i),
    .stride_i   (dst_str),
    .step_i     (step),
    .step_lvl_i (step_lvl),
    .addr_o     (cmd_dst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   len_q <= '0;
    else if (load) len_q <= burst_len_i;
  end
  assign cmd_len_o = len_q;

  assert_cmd_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=>
      (cmd_valid_o && $stable(cmd_src_o) && $stable(cmd_dst_o) && $stable(cmd_len_o)));
endmodule

// File: tb/strided_dma_agen_test.sv
module strided_dma_agen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] src_base;
  logic [47:0] dst_base;
  logic [15:0] blen;
  logic [15:0] rows;
  logic [20:0] rs0;
  logic [39:0] rd0;
  logic [1:0]  oen;
  logic [41:0] ocnt;
  logic [41:0] osrc;
  logic [79:0] odst;
  logic        vld, rdy, busy, done, err;
  logic [31:0] csrc;
  logic [47:0] cdst;
  logic [15:0] clen;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  strided_dma_agen uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .src_base_i(src_base), .dst_base_i(dst_base), .burst_len_i(blen),
    .row_cnt_i(rows), .row_src_stride_i(rs0), .row_dst_stride_i(rd0),
    .outer_en_i(oen), .outer_cnt_i(ocnt), .outer_src_stride_i(osrc),
    .outer_dst_stride_i(odst),
    .cmd_valid_o(vld), .cmd_ready_i(rdy), .cmd_src_o(csrc), .cmd_dst_o(cdst),
    .cmd_len_o(clen), .busy_o(busy), .done_o(done), .err_o(err)
  );

  // captured descriptor copy used for expectations
  logic [31:0] d_src;
  logic [47:0] d_dst;
  logic [15:0] d_len, d_rows;
  logic [20:0] d_rs0;
  logic [39:0] d_rd0;
  logic [1:0]  d_en;
  logic [20:0] d_cnt [2];
  logic [20:0] d_ss  [2];
  logic [39:0] d_ds  [2];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic drive_desc();
    src_base = d_src; dst_base = d_dst; blen = d_len; rows = d_rows;
    rs0 = d_rs0; rd0 = d_rd0; oen = d_en;
    ocnt = {d_cnt[1], d_cnt[0]};
    osrc = {d_ss[1], d_ss[0]};
    odst = {d_ds[1], d_ds[0]};
  endtask

  task automatic scramble();
    src_base = $urandom; dst_base = {$urandom, $urandom}; blen = $urandom;
    rows = $urandom; rs0 = $urandom; rd0 = {$urandom, $urandom};
    oen = $urandom; ocnt = {$urandom, $urandom};
    osrc = {$urandom, $urandom}; odst = {$urandom, $urandom, $urandom};
  endtask

  function automatic logic [31:0] exp_src(int i0, int i1, int i2);
    return d_src + 32'(i0) * 32'(d_rs0) + 32'(i1) * 32'(d_ss[0]) + 32'(i2) * 32'(d_ss[1]);
  endfunction

  function automatic logic [47:0] exp_dst(int i0, int i1, int i2);
    return d_dst + 48'(i0) * 48'(d_rd0) + 48'(i1) * 48'(d_ds[0]) + 48'(i2) * 48'(d_ds[1]);
  endfunction

  task automatic run_op(input int ready_pct, input bit poke);
    bit illegal;
    int n1, n2;
    bit r;
    @(negedge clk);
    drive_desc();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    scramble();  // R8: fields after start must not matter
    illegal = (d_rows == 0) || (d_en[0] && d_cnt[0] == 0) ||
              (d_en[1] && d_cnt[1] == 0) || (d_src[4:0] != 0);
    if (illegal) begin
      chk(done == 1'b1, "R7", "done", 64'(done), 64'd1);
      chk(err == 1'b1, "R7", "err", 64'(err), 64'd1);
      chk(vld == 1'b0 && busy == 1'b0, "R7", "valid", 64'(vld), 64'd0);
      @(negedge clk);
      chk(done == 1'b0 && err == 1'b0 && vld == 1'b0, "R7", "pulse end", 64'({done, err, vld}), 64'd0);
      return;
    end
    n1 = d_en[0] ? int'(d_cnt[0]) : 1;  // R4
    n2 = d_en[1] ? int'(d_cnt[1]) : 1;
    for (int i2 = 0; i2 < n2; i2++) begin
      for (int i1 = 0; i1 < n1; i1++) begin
        for (int i0 = 0; i0 < int'(d_rows); i0++) begin
          do begin
            chk(vld == 1'b1 && busy == 1'b1, "R2", "valid", 64'(vld), 64'd1);
            chk(csrc == exp_src(i0, i1, i2), "R3", "src", 64'(csrc), 64'(exp_src(i0, i1, i2)));
            chk(cdst == exp_dst(i0, i1, i2), "R3", "dst", 64'(cdst), 64'(exp_dst(i0, i1, i2)));
            chk(clen == d_len, "R9", "len", 64'(clen), 64'(d_len));
            r = (($urandom % 100) < ready_pct);
            rdy = r;
            if (poke && ($urandom % 4 == 0)) begin
              start = 1'b1;  // R8: ignored while busy
              scramble();
            end
            @(negedge clk);
            rdy = 1'b0;
            start = 1'b0;
          end while (!r);  // R5: stalled command rechecked unchanged
        end
      end
    end
    chk(done == 1'b1 && err == 1'b0, "R6", "done/err", 64'({done, err}), 64'b10);
    chk(vld == 1'b0 && busy == 1'b0, "R6", "idle", 64'({vld, busy}), 64'd0);
    @(negedge clk);
    chk(done == 1'b0, "R6", "done pulse width", 64'(done), 64'd0);
  endtask

  task automatic set_desc(input logic [31:0] s, input logic [47:0] d, input logic [15:0] l,
                          input logic [15:0] n0, input logic [20:0] s0, input logic [39:0] t0,
                          input logic [1:0] en,
                          input logic [20:0] c1, input logic [20:0] s1, input logic [39:0] t1,
                          input logic [20:0] c2, input logic [20:0] s2, input logic [39:0] t2);
    d_src = s; d_dst = d; d_len = l; d_rows = n0; d_rs0 = s0; d_rd0 = t0; d_en = en;
    d_cnt[0] = c1; d_ss[0] = s1; d_ds[0] = t1;
    d_cnt[1] = c2; d_ss[1] = s2; d_ds[1] = t2;
  endtask

  initial begin
    #(20 * 150000);
    vectors++;
    miscompares++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; rdy = 1'b0;
    set_desc('0, '0, '0, '0, '0, '0, '0, '0, '0, '0, '0, '0, '0);
    drive_desc();
    repeat (3) @(negedge clk);
    chk(vld == 0 && busy == 0 && done == 0 && err == 0, "R1", "reset outputs",
        64'({vld, busy, done, err}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(vld == 0 && busy == 0 && done == 0 && err == 0, "R1", "idle after reset",
        64'({vld, busy, done, err}), 64'd0);

    // single row, both outer groups disabled with junk fields (R4)
    set_desc(32'h0000_1000, 48'h12_0000_0000, 16'd48, 16'd1, 21'h1fffff, 40'hff_ffff_ffff,
             2'b00, 21'd0, 21'h1234, 40'h55, 21'd9, 21'h77, 40'h99);
    run_op(100, 1'b0);
    // rows x group 1 only, group 0 disabled (R4)
    set_desc(32'h0000_0020, 48'h0, 16'd7, 16'd3, 21'd64, 40'd100,
             2'b10, 21'd0, 21'h1ffff, 40'h1, 21'd2, 21'd4096, 40'd8192);
    run_op(60, 1'b1);
    // three levels with maximal strides, wrapping both address spaces (R3)
    set_desc(32'hffff_ffe0, 48'hffff_ffff_ff00, 16'hffff, 16'd3, 21'h1fffff, 40'hff_ffff_ffff,
             2'b11, 21'd2, 21'h1fffe0, 40'hff_ffff_fff0, 21'd2, 21'h100000, 40'h80_0000_0000);
    run_op(50, 1'b1);
    // illegal descriptors (R7)
    set_desc(32'h40, 48'h0, 16'd4, 16'd0, 21'd32, 40'd4, 2'b00, 21'd1, 21'd0, 40'd0, 21'd1, 21'd0, 40'd0);
    run_op(100, 1'b0);
    set_desc(32'h40, 48'h0, 16'd4, 16'd2, 21'd32, 40'd4, 2'b10, 21'd3, 21'd0, 40'd0, 21'd0, 21'd0, 40'd0);
    run_op(100, 1'b0);
    set_desc(32'h44, 48'h0, 16'd4, 16'd2, 21'd32, 40'd4, 2'b00, 21'd1, 21'd0, 40'd0, 21'd1, 21'd0, 40'd0);
    run_op(100, 1'b0);
    // bit 5 set is still aligned (R7)
    set_desc(32'h60, 48'h3, 16'd4, 16'd2, 21'd32, 40'd4, 2'b01, 21'd2, 21'd256, 40'd1000, 21'd0, 21'd0, 40'd0);
    run_op(100, 1'b0);

    for (int k = 0; k < 160; k++) begin
      logic [31:0] s;
      s = ($urandom % 8 == 0) ? $urandom : ($urandom & 32'hffff_ffe0);
      set_desc(s, {$urandom, $urandom}, 16'($urandom), 16'($urandom % 5),
               21'($urandom), 40'({$urandom, $urandom}), 2'($urandom),
               21'($urandom % 4), 21'($urandom), 40'({$urandom, $urandom}),
               21'($urandom % 4), 21'($urandom), 40'({$urandom, $urandom}));
      run_op(20 + int'($urandom % 81), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule